// File: doc/BRIEF.md
# Free-Running Timer with Cross-Domain Register Access

This block is a 32-bit free-running timer whose counter lives in a slow timer clock domain, nominally 3 MHz. Software reaches it through a simple register port in the bus clock domain. The port has a valid strobe, a write flag, an address and write data. Read data is returned combinationally.

The timer domain holds four match registers. When the counter equals a match value, an event is carried back to the bus domain. There it sets a status bit if the matching enable bit is set, and the interrupt line is the OR of the enabled status bits.

Every access that reaches into the timer domain passes through its own toggle handshake, and a pending flag for it is visible to software:

- a counter write,
- a write to each match register,
- a counter snapshot request.

Software must wait for the pending flag to clear before touching that register again. A write issued while its flag is still set is dropped. To read the counter, software sets bit 0 of the control register and waits for the snapshot flag to clear. The counter register then returns the captured value.

Top module: `synctimer`

## Requirements
- R1: After reset every register reads zero (match 0x00/0x04/0x08/0x0C, counter 0x10, status 0x14, enable 0x1C, control 0x20, access status 0x24), and irq is low.
- R2: The timer-domain counter advances by one on every timer clock and wraps from 0xFFFFFFFF to 0.
- R3: Writing 1 to bit 0 of control (0x20) sets access-status bit 5 until a counter snapshot has come back. Once bit 5 is clear, reading 0x10 returns the counter value at the time of capture.
- R4: A write to 0x10 sets access-status bit 4 until the counter in the timer domain has been loaded. Counting then continues from the written value.
- R5: A write to match n (offset 4·n, n = 0..3) sets access-status bit n until the value has reached the timer domain. Reading the offset returns the written value.
- R6: A write to the counter or to a match register while its pending bit is set is dropped, and the earlier value stays in effect.
- R7: When the counter equals match n while enable bit n (0x1C bits 3:0) is set, status bit n (0x14 bits 3:0) becomes 1.
- R8: A match whose enable bit is clear leaves its status bit at 0.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R10: irq is the OR of the status bits whose enable bits are set. Clearing an enable bit drops irq while the status bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Timer clock, asynchronous to clk and slower than it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_valid | input | 1 | Access strobe, one bus cycle per write |
| bus_write | input | 1 | Write when high |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Several internal faults show up only through the pending bits and the values that come back later:

- A request toggle that fails to return leaves its access-status bit stuck high, and the poll loop times out.
- A lost load leaves the next counter snapshot far from the written value, one handshake round trip later.
- A dropped or duplicated match event shows in the status register within a few bus cycles of the match in the timer domain.
- An accepted write that should have been ignored changes the match readback at once.
- A wrong snapshot path returns a counter value outside the window of timer clocks that elapsed between the load and the read.

// File: rtl/synctimer_pkg.sv
`timescale 1ns/1ps
package synctimer_pkg;
  localparam int NM = 4;
  localparam int AW = 6;
  localparam logic [AW-1:0] OFS_COUNT = 6'h10;
  localparam logic [AW-1:0] OFS_STAT  = 6'h14;
  localparam logic [AW-1:0] OFS_IEN   = 6'h1C;
  localparam logic [AW-1:0] OFS_CTRL  = 6'h20;
  localparam logic [AW-1:0] OFS_ACC   = 6'h24;
  localparam int ACC_CNT_W = NM;
  localparam int ACC_SNAP  = NM + 1;

  function automatic logic [AW-1:0] match_offset(input int n);
    return AW'(n * 4);
  endfunction

  function automatic logic [31:0] count_next(input logic [31:0] cur, input logic ld,
                                             input logic [31:0] val);
    return ld ? val : cur + 32'd1;
  endfunction

  function automatic logic [NM-1:0] status_next(input logic [NM-1:0] cur,
                                                input logic [NM-1:0] set,
                                                input logic [NM-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/synctimer_xfer.sv
`timescale 1ns/1ps
module synctimer_xfer #(
  parameter int W = 32
) (
  input  logic         s_clk,
  input  logic         d_clk,
  input  logic         rst_n,
  input  logic         s_start,
  input  logic [W-1:0] s_data,
  output logic         s_busy,
  output logic         d_load,
  output logic [W-1:0] d_data
);
  logic         req_t, ack_t;
  logic [1:0]   req_sy, ack_sy;
  logic [W-1:0] hold;
  logic         s_take;

  assign s_take = s_start & ~s_busy;
  assign s_busy = req_t ^ ack_sy[1];

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t  <= 1'b0;
      hold   <= '0;
      ack_sy <= '0;
    end else begin
      ack_sy <= {ack_sy[0], ack_t};
      if (s_take) begin
        req_t <= ~req_t;
        hold  <= s_data;
      end
    end
  end

  assign d_load = req_sy[1] ^ ack_t;
  assign d_data = hold;

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sy <= '0;
      ack_t  <= 1'b0;
    end else begin
      req_sy <= {req_sy[0], req_t};
      ack_t  <= req_sy[1];
    end
  end

  a_r6_hold_while_busy: assert property (@(posedge s_clk) disable iff (!rst_n)
    (s_start && s_busy) |=> $stable(hold));
  a_r4_single_load: assert property (@(posedge d_clk) disable iff (!rst_n)
    d_load |=> !d_load);
endmodule

// File: rtl/synctimer_core.sv
`timescale 1ns/1ps
module synctimer_core
  import synctimer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic                   tclk,
  input  logic                   rst_n,
  input  logic                   cnt_load,
  input  logic [TW-1:0]          cnt_val,
  input  logic [NM-1:0]          mt_load,
  input  logic [NM-1:0][TW-1:0]  mt_val,
  input  logic                   snap_load,
  input  logic                   snap_go,
  output logic [TW-1:0]          snap_val,
  output logic [NM-1:0]          hit_tog
);
  logic [TW-1:0]         cnt;
  logic [NM-1:0][TW-1:0] mt;
  logic [NM-1:0]         hit_now;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      snap_val <= '0;
    end else begin
      cnt <= count_next(cnt, cnt_load, cnt_val);
      if (snap_load && snap_go) snap_val <= cnt;
    end
  end

  for (genvar n = 0; n < NM; n++) begin : g_match
    assign hit_now[n] = (cnt == mt[n]);
    always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
        mt[n]      <= '0;
        hit_tog[n] <= 1'b0;
      end else begin
        if (mt_load[n]) mt[n] <= mt_val[n];
        if (hit_now[n]) hit_tog[n] <= ~hit_tog[n];
      end
    end
  end

  a_r2_count_step: assert property (@(posedge tclk) disable iff (!rst_n)
    !cnt_load |=> cnt == $past(cnt) + 32'd1);
  a_r4_count_loaded: assert property (@(posedge tclk) disable iff (!rst_n)
    cnt_load |=> cnt == $past(cnt_val));
endmodule

// File: rtl/synctimer.sv
`timescale 1ns/1ps
module synctimer
  import synctimer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          tclk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_wdata,
  output logic [TW-1:0] bus_rdata,
  output logic          irq
);
  logic                  wr, wr_cnt, wr_stat, wr_ien, snap_start;
  logic [NM-1:0]         wr_match, m_busy, m_load;
  logic [NM-1:0][TW-1:0] match_q, m_data;
  logic                  c_busy, c_load, r_busy, r_load, r_go, r_busy_q, r_done;
  logic [TW-1:0]         c_data, snap_t, snap_q;
  logic [NM-1:0]         status, ien, hit_tog, ev_s1, ev_s2, ev_q, ev_pulse, ev_set;
  logic [5:0]            acc;

  assign wr         = bus_valid & bus_write;
  assign wr_cnt     = wr && bus_addr == OFS_COUNT;
  assign wr_stat    = wr && bus_addr == OFS_STAT;
  assign wr_ien     = wr && bus_addr == OFS_IEN;
  assign snap_start = wr && bus_addr == OFS_CTRL && bus_wdata[0];
  assign acc        = {r_busy, c_busy, m_busy};

  for (genvar n = 0; n < NM; n++) begin : g_mch
    assign wr_match[n] = wr && bus_addr == match_offset(n);
    synctimer_xfer #(.W(TW)) u_mx (
      .s_clk(clk), .d_clk(tclk), .rst_n(rst_n), .s_start(wr_match[n]),
      .s_data(bus_wdata), .s_busy(m_busy[n]), .d_load(m_load[n]), .d_data(m_data[n]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q[n] <= '0;
      else if (wr_match[n] && !m_busy[n]) match_q[n] <= bus_wdata;
    end
    a_r6_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_match[n] && m_busy[n]) |=> $stable(match_q[n]));
    a_r7_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[n]) |-> $past(ien[n]) && $past(ev_pulse[n]));
  end

  synctimer_xfer #(.W(TW)) u_cx (
    .s_clk(clk), .d_clk(tclk), .rst_n(rst_n), .s_start(wr_cnt),
    .s_data(bus_wdata), .s_busy(c_busy), .d_load(c_load), .d_data(c_data));

  synctimer_xfer #(.W(1)) u_rx (
    .s_clk(clk), .d_clk(tclk), .rst_n(rst_n), .s_start(snap_start),
    .s_data(1'b1), .s_busy(r_busy), .d_load(r_load), .d_data(r_go));

  synctimer_core #(.TW(TW)) u_core (
    .tclk(tclk), .rst_n(rst_n), .cnt_load(c_load), .cnt_val(c_data),
    .mt_load(m_load), .mt_val(m_data), .snap_load(r_load), .snap_go(r_go),
    .snap_val(snap_t), .hit_tog(hit_tog));

  assign r_done   = r_busy_q & ~r_busy;
  assign ev_pulse = ev_s2 ^ ev_q;
  assign ev_set   = ev_pulse & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_busy_q <= 1'b0;
      snap_q   <= '0;
      ev_s1    <= '0;
      ev_s2    <= '0;
      ev_q     <= '0;
      status   <= '0;
      ien      <= '0;
    end else begin
      r_busy_q <= r_busy;
      if (r_done) snap_q <= snap_t;
      ev_s1  <= hit_tog;
      ev_s2  <= ev_s1;
      ev_q   <= ev_s2;
      status <= status_next(status, ev_set, wr_stat ? bus_wdata[NM-1:0] : '0);
      if (wr_ien) ien <= bus_wdata[NM-1:0];
    end
  end

  assign irq = |(status & ien);

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NM; n++)
      if (bus_addr == match_offset(n)) bus_rdata = match_q[n];
    case (bus_addr)
      OFS_COUNT: bus_rdata = snap_q;
      OFS_STAT:  bus_rdata = TW'(status);
      OFS_IEN:   bus_rdata = TW'(ien);
      OFS_ACC:   bus_rdata = TW'(acc);
      default:   ;
    endcase
  end

  a_r3_snap_pending: assert property (@(posedge clk) disable iff (!rst_n)
    snap_start |=> acc[ACC_SNAP]);
  a_r4_count_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> acc[ACC_CNT_W]);
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (status & $past(bus_wdata[NM-1:0]) & ~$past(ev_set)) == '0);
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien != '0);
endmodule

// File: tb/synctimer_test.sv
`timescale 1ns/1ps
module synctimer_test;
  logic clk = 0, tclk = 0, rst_n = 0;
  logic bv = 0, bw = 0;
  logic [5:0] ba = 0;
  logic [31:0] bwd = 0;
  logic [31:0] brd;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #30 tclk = ~tclk;

  synctimer uut (.clk(clk), .tclk(tclk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw),
    .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(brd), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [31:0] got,
                         input logic [31:0] lo, input logic [31:0] hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s got %h exp %h..%h", tag, got, lo, hi);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bv = 1; bw = 1; ba = a; bwd = d;
    @(negedge clk); bv = 0; bw = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); ba = a; #1 d = brd;
  endtask

  task automatic wait_idle(input logic [31:0] mask);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(6'h24, v);
      if ((v & mask) == 0) return;
    end
    chk("pending bit never cleared", v & mask, 0);
  endtask

  task automatic snap(output logic [31:0] d);
    wr(6'h20, 1);
    wait_idle(32'h20);
    rd(6'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a <= 6'h24; a += 4) begin
      rd(6'(a), v);
      chk($sformatf("R1 reset value at %h", a), v, 0);
    end
    chk("R1 irq low after reset", 32'(irq), 0);
  endtask

  task automatic t_match_rw;
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin
      wr(6'(n * 4), 32'hA5000000 + 32'(n));
      rd(6'h24, v);
      chk($sformatf("R5 match%0d pending bit", n), v & (32'd1 << n), 32'd1 << n);
    end
    wait_idle(32'h0F);
    for (int n = 0; n < 4; n++) begin
      rd(6'(n * 4), v);
      chk($sformatf("R5 match%0d readback", n), v, 32'hA5000000 + 32'(n));
    end
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    wr(6'h04, 32'h11112222);
    wr(6'h04, 32'h33334444);
    wait_idle(32'h02);
    rd(6'h04, v);
    chk("R6 second match write dropped", v, 32'h11112222);
    wr(6'h10, 32'h00001000);
    wr(6'h10, 32'h90000000);
    wait_idle(32'h10);
    snap(v);
    chk_rng("R6 second counter write dropped", v, 32'h1000, 32'h1020);
  endtask

  task automatic t_count;
    logic [31:0] v, s1, s2;
    wr(6'h10, 32'h100);
    rd(6'h24, v);
    chk("R4 counter write pending bit", v & 32'h10, 32'h10);
    wait_idle(32'h10);
    wr(6'h20, 1);
    rd(6'h24, v);
    chk("R3 snapshot pending bit", v & 32'h20, 32'h20);
    wait_idle(32'h20);
    rd(6'h10, s1);
    chk_rng("R4 count continues from written value", s1, 32'h100, 32'h110);
    repeat (10) @(posedge tclk);
    snap(s2);
    chk_rng("R3 R2 snapshot advances one per timer clock", s2 - s1, 10, 20);
    wr(6'h10, 32'hFFFFFFF8);
    wait_idle(32'h10);
    repeat (20) @(posedge tclk);
    snap(v);
    chk_rng("R2 counter wraps past all ones", v, 32'h0C, 32'h30);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(6'h1C, 32'h1);
    wr(6'h00, 32'h2000 + 30);
    wr(6'h08, 32'h2000 + 30);
    wait_idle(32'h05);
    wr(6'h10, 32'h2000);
    wait_idle(32'h10);
    repeat (60) @(posedge tclk);
    rd(6'h14, v);
    chk("R7 status bit0 set on enabled match", v & 32'h1, 32'h1);
    chk("R8 status bit2 stays clear without enable", v & 32'h4, 0);
    chk("R10 irq high with enabled status", 32'(irq), 1);
    wr(6'h1C, 32'h0);
    rd(6'h14, v);
    chk("R10 irq drops when enable cleared", 32'(irq), 0);
    chk("R10 status kept when enable cleared", v & 32'h1, 32'h1);
    wr(6'h1C, 32'h1);
    wr(6'h14, 32'h0);
    rd(6'h14, v);
    chk("R9 writing zero leaves status", v & 32'h1, 32'h1);
    wr(6'h14, 32'h1);
    rd(6'h14, v);
    chk("R9 write one clears status", v & 32'h1, 0);
    chk("R9 irq low after clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_match_rw;
    t_ignore;
    t_count;
    t_irq;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule